// File: doc/BRIEF.md
# Cache Operation Filter Counter

This block sits beside a shared last-level cache and counts the operations that satisfy a programmable set of conditions. For every operation the cache presents the index of the requesting core or thread, a 3-bit request-type tag, a 5-bit code naming where the data came from, and two 11-bit cluster identifiers: one for the source and one for the target. Each cluster identifier holds a 6-bit super-cluster number in bits 10:5 and a 5-bit cluster number in bits 4:0.

Five independent filters can be applied to each operation: a core bitmap, a request-type match, a data-source match, a masked source-ID compare and a masked target-ID compare. Each filter has its own enable bit. An operation increments the counter only when every enabled filter accepts it. When all filters are off, every operation is counted. The counter is 48 bits wide by default and has a sticky overflow flag. It is started, stopped and cleared through a small register write port, which also loads the filter settings.

Top module: `cache_evt_filter_counter`

## Requirements
- R1: After reset, `count` is 0, `overflow` is 0, counting is disabled and all five filters are disabled.
- R2: When counting is enabled and no filter is enabled, each cycle with `op_valid` high raises `count` by one, visible after the next rising clock edge. Cycles with `op_valid` low, and all cycles while counting is disabled, leave `count` unchanged.
- R3: When the core filter is enabled, an operation is counted only if bit `op_core` of the core bitmap is 1.
- R4: When the request filter is enabled, an operation is counted only if `op_req` equals the programmed code. The valid codes are 3'b100 (read), 3'b101 (write), 3'b110 (atomic store) and 3'b111 (atomic non-store).
- R5: When the request filter is enabled with a reserved code (bit 2 equal to 0), no operation is counted, even one whose tag equals that code.
- R6: When the data-source filter is enabled, an operation is counted only if `op_dsrc` equals the programmed 5-bit code (for example 5'b01110 for local DDR or 5'b00001 for the local-die cache).
- R7: When the source-ID filter is enabled, an operation is counted only if `op_src_id` equals the programmed command value in every bit position where the programmed mask bit is 0. Positions with a mask bit of 1 are ignored.
- R8: The target-ID filter applies the same masked compare to `op_tgt_id`, using its own command and mask values.
- R9: When several filters are enabled, an operation is counted only if all of them accept it. An operation that fails any one enabled filter is not counted.
- R10: A control write with bit 1 set clears `count` and `overflow` at that clock edge. The clear takes priority over an increment in the same cycle, so the result is 0.
- R11: An increment from the all-ones value wraps `count` to 0 and sets `overflow`. `overflow` stays at 1 until it is cleared.
- R12: The register map, with writes taking effect at the clock edge where `wr_en` is high:
  - Address 0 (control): bit 0 enables counting; bit 1 is a clear strobe that is not stored.
  - Address 1 (filter enables): bit 0 core, bit 1 request, bit 2 data source, bit 3 source ID, bit 4 target ID.
  - Address 2: the core bitmap.
  - Address 3: request code in bits 2:0 and data-source code in bits 12:8.
  - Address 4: source command in bits 10:0 and source mask in bits 26:16.
  - Address 5: target command in bits 10:0 and target mask in bits 26:16.
  - Settings other than the clear strobe apply from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| op_valid | input | 1 | A cache operation is present this cycle |
| op_core | input | CORE_W (4) | Requesting core/thread index |
| op_req | input | 3 | Request-type tag |
| op_dsrc | input | 5 | Data-source code |
| op_src_id | input | 11 | Source cluster ID |
| op_tgt_id | input | 11 | Target cluster ID |
| count | output | CNT_W (48) | Event count |
| overflow | output | 1 | Sticky wrap flag |

## Verification
Two events can fall in the same cycle: a control write carrying the clear strobe, and an accepted operation that would increment the counter. The bench provokes this by presenting a valid, accepted operation in the very cycle the clear is written. It then expects a count of 0 and a cleared overflow, not a count of 1. The same collision is run after a wrap, so that the clear is also seen to drop a set overflow flag in the cycle where another increment is arriving.

// File: rtl/cefc_pkg.sv
package cefc_pkg;
  localparam int REQ_W  = 3;
  localparam int DSRC_W = 5;
  localparam int ID_W   = 11;
  localparam int NFILT  = 5;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_FEN   = 3'd1,
    REG_CORE  = 3'd2,
    REG_CODE  = 3'd3,
    REG_SRCID = 3'd4,
    REG_TGTID = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic tgt_id;
    logic src_id;
    logic dsrc;
    logic req;
    logic core;
  } filt_en_t;

  // masked compare: bits whose mask is set are don't-care
  function automatic logic id_hit(input logic [ID_W-1:0] op_id,
                                  input logic [ID_W-1:0] cmd,
                                  input logic [ID_W-1:0] msk);
    return ((op_id ^ cmd) & ~msk) == '0;
  endfunction

  // reserved programmed codes (bit 2 clear) never match
  function automatic logic req_hit(input logic [REQ_W-1:0] op_req,
                                   input logic [REQ_W-1:0] code);
    return code[REQ_W-1] && (op_req == code);
  endfunction
endpackage

// File: rtl/cefc_regs.sv
module cefc_regs
  import cefc_pkg::*;
#(
  parameter int NCORES = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cnt_en,
  output logic              clr_pulse,
  output filt_en_t          fen,
  output logic [NCORES-1:0] core_map,
  output logic [REQ_W-1:0]  req_code,
  output logic [DSRC_W-1:0] dsrc_code,
  output logic [ID_W-1:0]   sid_cmd,
  output logic [ID_W-1:0]   sid_msk,
  output logic [ID_W-1:0]   tid_cmd,
  output logic [ID_W-1:0]   tid_msk
);
  localparam int DSRC_LSB = 8;
  localparam int MSK_LSB  = 16;

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  logic sel_ctrl, sel_fen, sel_core, sel_code, sel_sid, sel_tid;
  assign sel_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign sel_fen  = wr_en && (wr_addr == REG_FEN);
  assign sel_core = wr_en && (wr_addr == REG_CORE);
  assign sel_code = wr_en && (wr_addr == REG_CODE);
  assign sel_sid  = wr_en && (wr_addr == REG_SRCID);
  assign sel_tid  = wr_en && (wr_addr == REG_TGTID);

  assign clr_pulse = sel_ctrl && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_en    <= 1'b0;
      fen       <= '0;
      core_map  <= '0;
      req_code  <= '0;
      dsrc_code <= '0;
      sid_cmd   <= '0;
      sid_msk   <= '0;
      tid_cmd   <= '0;
      tid_msk   <= '0;
    end else begin
      if (sel_ctrl) cnt_en <= wr_data[0];
      if (sel_fen)  fen    <= filt_en_t'(wr_data[NFILT-1:0]);
      if (sel_core) core_map <= wr_data[NCORES-1:0];
      if (sel_code) begin
        req_code  <= wr_data[REQ_W-1:0];
        dsrc_code <= wr_data[DSRC_LSB +: DSRC_W];
      end
      if (sel_sid) begin
        sid_cmd <= wr_data[ID_W-1:0];
        sid_msk <= wr_data[MSK_LSB +: ID_W];
      end
      if (sel_tid) begin
        tid_cmd <= wr_data[ID_W-1:0];
        tid_msk <= wr_data[MSK_LSB +: ID_W];
      end
    end
  end

  // R1: registers come out of reset with counting and filters off
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!cnt_en && fen == '0));
endmodule

// File: rtl/cefc_match.sv
module cefc_match
  import cefc_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int NCORES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [CORE_W-1:0] op_core,
  input  logic [REQ_W-1:0]  op_req,
  input  logic [DSRC_W-1:0] op_dsrc,
  input  logic [ID_W-1:0]   op_src_id,
  input  logic [ID_W-1:0]   op_tgt_id,
  input  filt_en_t          fen,
  input  logic [NCORES-1:0] core_map,
  input  logic [REQ_W-1:0]  req_code,
  input  logic [DSRC_W-1:0] dsrc_code,
  input  logic [ID_W-1:0]   sid_cmd,
  input  logic [ID_W-1:0]   sid_msk,
  input  logic [ID_W-1:0]   tid_cmd,
  input  logic [ID_W-1:0]   tid_msk,
  output logic              accept
);
  // named per-filter pass results for the assertions
  logic core_ok, req_ok, dsrc_ok;
  logic [1:0] id_ok;

  logic [1:0][ID_W-1:0] id_op, id_cmd, id_msk;
  logic [1:0]           id_en;
  assign id_op  = {op_tgt_id, op_src_id};
  assign id_cmd = {tid_cmd, sid_cmd};
  assign id_msk = {tid_msk, sid_msk};
  assign id_en  = {fen.tgt_id, fen.src_id};

  assign core_ok = !fen.core || core_map[op_core];
  assign req_ok  = !fen.req  || req_hit(op_req, req_code);
  assign dsrc_ok = !fen.dsrc || (op_dsrc == dsrc_code);

  for (genvar k = 0; k < 2; k++) begin : g_idcmp
    assign id_ok[k] = !id_en[k] || id_hit(id_op[k], id_cmd[k], id_msk[k]);
  end

  assign accept = op_valid && core_ok && req_ok && dsrc_ok && (&id_ok);

  // R5: a reserved programmed request code lets nothing through
  a_r5_reserved_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fen.req && !req_code[REQ_W-1]) |-> !accept);
  // R3: a core outside the bitmap is never accepted
  a_r3_core_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fen.core && !core_map[op_core]) |-> !accept);
  // R6: a mismatched data source is never accepted
  a_r6_dsrc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fen.dsrc && op_dsrc != dsrc_code) |-> !accept);
  // R2: with every filter off, any valid operation is accepted
  a_r2_open_path: assert property (@(posedge clk) disable iff (!rst_n)
    (fen == '0 && op_valid) |-> accept);
endmodule

// File: rtl/cefc_counter.sv
module cefc_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  assign wrap = inc && !clr && (count == ALL1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (inc) begin
      count <= count + 1'b1;
      if (wrap) overflow <= 1'b1;
    end
  end

  // R10: clear wins over a coincident increment
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !overflow));
  // R2: an increment advances by exactly one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (count == $past(count) + 1'b1));
  // R2: no increment, no clear, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));
  // R11: wrap goes to zero and raises the flag
  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0 && overflow));
  // R11: flag is sticky until cleared
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);
endmodule

// File: rtl/cache_evt_filter_counter.sv
module cache_evt_filter_counter
  import cefc_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_valid,
  input  logic [CORE_W-1:0] op_core,
  input  logic [2:0]        op_req,
  input  logic [4:0]        op_dsrc,
  input  logic [10:0]       op_src_id,
  input  logic [10:0]       op_tgt_id,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  localparam int NCORES = 1 << CORE_W;

  logic              cnt_en, clr_pulse, accept, inc, wrap;
  filt_en_t          fen;
  logic [NCORES-1:0] core_map;
  logic [REQ_W-1:0]  req_code;
  logic [DSRC_W-1:0] dsrc_code;
  logic [ID_W-1:0]   sid_cmd, sid_msk, tid_cmd, tid_msk;

  cefc_regs #(.NCORES(NCORES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .clr_pulse(clr_pulse), .fen(fen),
    .core_map(core_map), .req_code(req_code), .dsrc_code(dsrc_code),
    .sid_cmd(sid_cmd), .sid_msk(sid_msk), .tid_cmd(tid_cmd), .tid_msk(tid_msk)
  );

  cefc_match #(.CORE_W(CORE_W), .NCORES(NCORES)) u_match (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_core(op_core),
    .op_req(op_req), .op_dsrc(op_dsrc), .op_src_id(op_src_id),
    .op_tgt_id(op_tgt_id), .fen(fen), .core_map(core_map),
    .req_code(req_code), .dsrc_code(dsrc_code), .sid_cmd(sid_cmd),
    .sid_msk(sid_msk), .tid_cmd(tid_cmd), .tid_msk(tid_msk), .accept(accept)
  );

  assign inc = cnt_en && accept;

  cefc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr_pulse),
    .count(count), .overflow(overflow), .wrap(wrap)
  );

  // R2: the counter never moves without a valid operation
  a_r2_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> op_valid);
  // R2: a stopped counter holds its value unless cleared
  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr_pulse) |=> $stable(count));
endmodule

// File: tb/tb_cache_evt_filter_counter.sv
module tb_cache_evt_filter_counter;
  localparam int CW = 8;
  localparam int CORE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic op_valid = 1'b0;
  logic [CORE_W-1:0] op_core = '0;
  logic [2:0] op_req = '0;
  logic [4:0] op_dsrc = '0;
  logic [10:0] op_src_id = '0, op_tgt_id = '0;
  logic [CW-1:0] count;
  logic overflow;

  always #5 clk = ~clk;

  cache_evt_filter_counter #(.CORE_W(CORE_W), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_valid(op_valid), .op_core(op_core),
    .op_req(op_req), .op_dsrc(op_dsrc), .op_src_id(op_src_id),
    .op_tgt_id(op_tgt_id), .count(count), .overflow(overflow)
  );

  int n_cmp = 0, n_bad = 0;

  // bench shadow of programmed state
  bit sh_en; bit [4:0] sh_fen; bit [15:0] sh_core;
  bit [2:0] sh_req; bit [4:0] sh_dsrc;
  bit [10:0] sh_scmd, sh_smsk, sh_tcmd, sh_tmsk;
  bit [CW-1:0] exp_cnt; bit exp_ovf;

  logic [CW-1:0] q_cnt[$];
  logic q_ovf[$];
  string q_tag[$];

  function automatic bit ids_agree(bit [10:0] a, bit [10:0] c, bit [10:0] m);
    for (int b = 0; b < 11; b++)
      if (!m[b] && a[b] != c[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit tag_agrees(bit [2:0] t, bit [2:0] cfg);
    case (cfg)
      3'b100, 3'b101, 3'b110, 3'b111: return t == cfg;
      default: return 1'b0;
    endcase
  endfunction

  task automatic cyc(bit we, bit [2:0] a, bit [31:0] d, bit v, bit [3:0] c,
                     bit [2:0] r, bit [4:0] ds, bit [10:0] s, bit [10:0] t,
                     string tag);
    bit pass, clr;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; op_valid = v; op_core = c;
    op_req = r; op_dsrc = ds; op_src_id = s; op_tgt_id = t;
    pass = v;
    if (sh_fen[0] && !sh_core[c]) pass = 0;
    if (sh_fen[1] && !tag_agrees(r, sh_req)) pass = 0;
    if (sh_fen[2] && ds != sh_dsrc) pass = 0;
    if (sh_fen[3] && !ids_agree(s, sh_scmd, sh_smsk)) pass = 0;
    if (sh_fen[4] && !ids_agree(t, sh_tcmd, sh_tmsk)) pass = 0;
    clr = we && a == 3'd0 && d[1];
    if (clr) begin exp_cnt = '0; exp_ovf = 0; end
    else if (sh_en && pass) begin
      if (&exp_cnt) exp_ovf = 1;
      exp_cnt = exp_cnt + 1'b1;
    end
    if (we) case (a)
      3'd0: sh_en = d[0];
      3'd1: sh_fen = d[4:0];
      3'd2: sh_core = d[15:0];
      3'd3: begin sh_req = d[2:0]; sh_dsrc = d[12:8]; end
      3'd4: begin sh_scmd = d[10:0]; sh_smsk = d[26:16]; end
      3'd5: begin sh_tcmd = d[10:0]; sh_tmsk = d[26:16]; end
      default: ;
    endcase
    q_cnt.push_back(exp_cnt); q_ovf.push_back(exp_ovf); q_tag.push_back(tag);
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d, string tag);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic op(bit [3:0] c, bit [2:0] r, bit [4:0] ds, bit [10:0] s,
                    bit [10:0] t, string tag);
    cyc(0, 0, 0, 1, c, r, ds, s, t, tag);
  endtask
  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compare after each edge that follows a pushed expectation
  always @(posedge clk) begin
    #2;
    if (q_cnt.size() > 0) begin
      logic [CW-1:0] ec; logic eo; string tg;
      ec = q_cnt.pop_front(); eo = q_ovf.pop_front(); tg = q_tag.pop_front();
      n_cmp++;
      if (count !== ec || overflow !== eo) begin
        n_bad++;
        $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
                 tg, count, overflow, ec, eo);
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    n_cmp++;
    if (count !== '0 || overflow !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: count=%0d ovf=%0b expected 0/0", count, overflow);
    end
    op(1, 3'b100, 5'd1, 0, 0, "R1 counting off after reset");
    op(2, 3'b101, 5'd2, 0, 0, "R1 filters idle, counting off");
    // R2 open counting
    wr(3'd0, 32'h1, "R12 ctrl enable");
    op(0, 3'b000, 5'd0, 0, 0, "R2 count any op");
    op(7, 3'b011, 5'd31, 11'h7FF, 11'h123, "R2 count any op 2");
    idle("R2 no valid no count");
    op(3, 3'b111, 5'd9, 0, 0, "R2 count any op 3");
    wr(3'd0, 32'h0, "R2 stop");
    op(3, 3'b111, 5'd9, 0, 0, "R2 stopped ignores op");
    wr(3'd0, 32'h1, "R2 restart");
    // R3 core bitmap
    wr(3'd2, 32'h0005, "R12 core map");
    wr(3'd1, 32'h01, "R12 enable core filter");
    op(0, 0, 0, 0, 0, "R3 core 0 selected");
    op(1, 0, 0, 0, 0, "R3 core 1 not selected");
    op(2, 0, 0, 0, 0, "R3 core 2 selected");
    op(15, 0, 0, 0, 0, "R3 core 15 not selected");
    // R4 request tag
    wr(3'd3, {19'd0, 5'b01110, 5'd0, 3'b101}, "R12 codes");
    wr(3'd1, 32'h02, "R12 enable req filter");
    op(0, 3'b101, 0, 0, 0, "R4 write matches");
    op(0, 3'b100, 0, 0, 0, "R4 read rejected");
    op(0, 3'b111, 0, 0, 0, "R4 atomic non-store rejected");
    // R5 reserved code
    wr(3'd3, {19'd0, 5'b01110, 5'd0, 3'b011}, "R12 reserved code");
    op(0, 3'b011, 0, 0, 0, "R5 reserved equal tag rejected");
    op(0, 3'b000, 0, 0, 0, "R5 reserved zero rejected");
    // R6 data source
    wr(3'd1, 32'h04, "R12 enable dsrc filter");
    op(0, 0, 5'b01110, 0, 0, "R6 local DDR matches");
    op(0, 0, 5'b01111, 0, 0, "R6 cross-die DDR rejected");
    // R7 source ID masked compare
    wr(3'd4, {5'd0, 11'h01F, 5'd0, 11'h2A5}, "R12 src id");
    wr(3'd1, 32'h08, "R12 enable src id filter");
    op(0, 0, 0, 11'h2A0, 0, "R7 masked low bits match");
    op(0, 0, 0, 11'h2BF, 0, "R7 masked low bits match 2");
    op(0, 0, 0, 11'h4A5, 0, "R7 super-cluster differs rejected");
    // R8 target ID masked compare
    wr(3'd5, {5'd0, 11'h400, 5'd0, 11'h033}, "R12 tgt id");
    wr(3'd1, 32'h10, "R12 enable tgt id filter");
    op(0, 0, 0, 0, 11'h433, "R8 top bit masked match");
    op(0, 0, 0, 0, 11'h032, "R8 low bit differs rejected");
    // R9 combined filters
    wr(3'd3, {19'd0, 5'b00001, 5'd0, 3'b100}, "R12 codes 2");
    wr(3'd1, 32'h07, "R12 enable core+req+dsrc");
    op(2, 3'b100, 5'b00001, 0, 0, "R9 all pass");
    op(1, 3'b100, 5'b00001, 0, 0, "R9 core fails");
    op(2, 3'b110, 5'b00001, 0, 0, "R9 req fails");
    op(2, 3'b100, 5'b01000, 0, 0, "R9 dsrc fails");
    // R10 clear collides with accepted op
    cyc(1, 3'd0, 32'h3, 1, 2, 3'b100, 5'b00001, 0, 0, "R10 clear beats increment");
    op(2, 3'b100, 5'b00001, 0, 0, "R10 counts again after clear");
    // R11 wrap
    wr(3'd1, 32'h0, "R12 filters off");
    for (int i = 0; i < (1 << CW); i++)
      op(i[3:0], 0, 0, 0, 0, "R11 run to wrap");
    op(0, 0, 0, 0, 0, "R11 flag sticky");
    cyc(1, 3'd0, 32'h3, 1, 0, 0, 0, 0, 0, "R10 clear drops overflow");
    idle("R10 settled");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule